// File: doc/BRIEF.md
# Bidirectional Pin Bank with Weak Pull-ups

This block is an eight-pin general-purpose I/O bank for a small microcontroller bus. Each pin has a direction bit and an output latch bit. A cleared direction bit enables the pin driver, which then drives the latch value. A set direction bit releases the pin so that it acts as an input. The bus reads and writes four byte-wide locations through an address, a write strobe and a read strobe. A separate single-bit set/clear strobe changes one latch bit with a read-modify-write.

A port read returns the pin levels after a two-flop synchronizer, not the latch. Any pin marked in the analog-select mask reads as zero. A single active-low option bit turns on weak pull-ups. The pull-up request reaches a pin only while that pin is an input. Pins are modelled as separate input, output and output-enable vectors, plus a vector of pull-up requests.

Address map: 0 = port (write sets the latch, read returns the pins), 1 = direction, 2 = analog-select mask, 3 = option. Bit 7 of the option register is the pull-up disable bit; 0 enables pull-ups. A read is registered, so `rdData` changes on the clock edge that samples `rdEn`.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the direction register is 0xFF, so `pinOe` is 0x00. The latch is 0x00, `pullUp` is 0x00, the option register reads 0x80, and the analog mask reads `ANALOG_RESET` (default 0x0F).
- R2: `pinOe[i]` is the inverse of direction bit i, and `pinOut` always equals the latch.
- R3: A write to address 0 changes only the latch. The new value appears on `pinOut` after that clock edge, and the direction register and analog mask do not change.
- R4: A read of address 0 returns the pin levels through a two-stage synchronizer, not the latch. A pin change is visible to a read issued two or more clock edges after the change.
- R5: A pin whose analog-mask bit is 1 reads as 0 at address 0. The mask can be written and read back at address 2.
- R6: When `bitWr` is high, the latch takes the synchronized and analog-masked pin value, with bit `bitIdx` replaced by `bitVal`. A byte write issued in the same cycle is ignored.
- R7: `pullUp[i]` is 1 only when option bit 7 is 0 and pin i is an input.
- R8: A read of address 1 returns exactly the last value written to the direction register.
- R9: A port read issued in the same cycle as a port write returns the previously synchronized pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | WIDTH | Write data |
| rdData | output | WIDTH | Registered read data |
| bitWr | input | 1 | Single-bit set/clear strobe on the latch |
| bitIdx | input | IDXW | Bit position for `bitWr` |
| bitVal | input | 1 | Value written into that bit |
| pinIn | input | WIDTH | Sampled pin levels |
| pinOut | output | WIDTH | Pin drive values |
| pinOe | output | WIDTH | Pin driver enables, 1 = driving |
| pullUp | output | WIDTH | Weak pull-up requests |

## Verification
The in-RTL assertions check, on every clock, the following:
- a pin never drives and requests a pull-up at the same time;
- the latch holds when it is not written;
- direction and latch writes land on the next edge;
- a single-bit operation sets the addressed pin output;
- a port read never returns a 1 on an analog-masked pin.

Only the bench scenarios can show the rest: that reads return pin levels rather than the latch, that the synchronizer delay holds, that input levels are copied into the latch by a read-modify-write, and that a byte write collides with a bit operation as specified.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [1:0] ADDR_PORT  = 2'd0;
  localparam logic [1:0] ADDR_DIR   = 2'd1;
  localparam logic [1:0] ADDR_ANSEL = 2'd2;
  localparam logic [1:0] ADDR_OPT   = 2'd3;

  typedef struct packed {
    logic       wrPort;
    logic       wrDir;
    logic       wrAnsel;
    logic       wrOpt;
    logic       bitOp;
    logic       rdEn;
    logic [1:0] rdSel;
  } gpioStb_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic [1:0] addr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       bitWr,
  output gpioStb_t   stb
);
  logic byteWr;

  // A bit operation owns the latch in its cycle: byte writes are dropped (R6)
  assign byteWr = wrEn && !bitWr;

  always_comb begin
    stb         = '0;
    stb.wrPort  = byteWr && (addr == ADDR_PORT);
    stb.wrDir   = byteWr && (addr == ADDR_DIR);
    stb.wrAnsel = byteWr && (addr == ADDR_ANSEL);
    stb.wrOpt   = byteWr && (addr == ADDR_OPT);
    stb.bitOp   = bitWr;
    stb.rdEn    = rdEn;
    stb.rdSel   = addr;
  end
endmodule

// File: rtl/gpio_dp.sv
module gpio_dp
  import gpio_pkg::*;
#(
  parameter int          WIDTH        = 8,
  parameter int          IDXW         = $clog2(WIDTH),
  parameter int          SYNC_STAGES  = 2,
  parameter logic [WIDTH-1:0] ANALOG_RESET = 8'h0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpioStb_t         stb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic             bitVal,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pullUp
);
  localparam int OPT_BIT = WIDTH - 1;

  logic [WIDTH-1:0] latchQ, dirQ, anselQ;
  logic             pullDisQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] pinView, rmwVal, rdNext;

  // Pin synchronizer chain (R4)
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= pinIn;
        else syncQ[s] <= syncQ[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  // Digital view of the pins: analog-selected bits read as zero (R5)
  assign pinView = syncQ[SYNC_STAGES-1] & ~anselQ;

  always_comb begin
    rmwVal         = pinView;
    rmwVal[bitIdx] = bitVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ   <= '0;
      dirQ     <= '1;
      anselQ   <= ANALOG_RESET;
      pullDisQ <= 1'b1;
    end else begin
      if (stb.bitOp)       latchQ <= rmwVal;
      else if (stb.wrPort) latchQ <= wrData;
      if (stb.wrDir)   dirQ     <= wrData;
      if (stb.wrAnsel) anselQ   <= wrData;
      if (stb.wrOpt)   pullDisQ <= wrData[OPT_BIT];
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      ADDR_PORT:  rdNext = pinView;
      ADDR_DIR:   rdNext = dirQ;
      ADDR_ANSEL: rdNext = anselQ;
      default: begin
        rdNext          = '0;
        rdNext[OPT_BIT] = pullDisQ;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdEn) rdData <= rdNext;
  end

  assign pinOut = latchQ;
  assign pinOe  = ~dirQ;
  assign pullUp = {WIDTH{~pullDisQ}} & dirQ;

  p_pull_vs_drive_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pullUp & pinOe) == '0);

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrPort || stb.bitOp) |=> $stable(pinOut));

  p_port_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrPort && !stb.bitOp) |=> pinOut == $past(wrData));

  p_dir_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDir |=> pinOe == ~$past(wrData));

  p_bit_op_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.bitOp |=> pinOut[$past(bitIdx)] == $past(bitVal));

  p_analog_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.rdSel == ADDR_PORT) |=> (rdData & $past(anselQ)) == '0);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter int               IDXW         = $clog2(WIDTH),
  parameter logic [WIDTH-1:0] ANALOG_RESET = 8'h0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       addr,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic             bitWr,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic             bitVal,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pullUp
);
  gpioStb_t stb;

  gpio_ctrl u_ctrl (
    .addr  (addr),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .bitWr (bitWr),
    .stb   (stb)
  );

  gpio_dp #(
    .WIDTH        (WIDTH),
    .IDXW         (IDXW),
    .SYNC_STAGES  (2),
    .ANALOG_RESET (ANALOG_RESET)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .bitIdx (bitIdx),
    .bitVal (bitVal),
    .pinIn  (pinIn),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .pullUp (pullUp)
  );
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] addr;
  logic       wrEn, rdEn, bitWr, bitVal;
  logic [7:0] wrData, rdData, pinIn, pinOut, pinOe, pullUp, extPins;
  logic [2:0] bitIdx;
  logic       issued;
  int         nChecks = 0;
  int         nFails  = 0;
  bit         finished = 0;
  logic [7:0] expQ [$];
  string      tagQ [$];

  always #2ns clk = ~clk;

  // Pins: driven pins loop back, released pins follow the external level
  assign pinIn = (pinOe & pinOut) | (~pinOe & extPins);

  gpio_bank dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .bitWr(bitWr), .bitIdx(bitIdx),
    .bitVal(bitVal), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .pullUp(pullUp)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) issued <= rdEn;

  // Monitor: compares each read result against the scoreboard queue
  always @(negedge clk) begin
    if (issued === 1'b1) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL scoreboard: unexpected read result %h expected none", rdData);
      end else begin
        check(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic bitOp(logic [2:0] idx, logic v, logic alsoWr);
    @(negedge clk);
    bitIdx = idx; bitVal = v; bitWr = 1'b1;
    addr = 2'd0; wrData = 8'hFF; wrEn = alsoWr;
    @(negedge clk);
    bitWr = 1'b0; wrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #400us;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rstN = 1'b0; addr = '0; wrEn = 0; rdEn = 0; wrData = '0;
    bitWr = 0; bitIdx = '0; bitVal = 0; extPins = 8'hA5;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'h00);
    check("R1 pullUp", pullUp, 8'h00);
    rdReg(2'd1, 8'hFF, "R1 dir");
    rdReg(2'd2, 8'h0F, "R1 ansel");
    rdReg(2'd3, 8'h80, "R1 option");

    // R4/R5 analog pins read zero
    settle();
    rdReg(2'd0, 8'hA0, "R5 analog masked read");
    wrReg(2'd2, 8'h00);
    rdReg(2'd2, 8'h00, "R5 ansel readback");
    rdReg(2'd0, 8'hA5, "R4 pin read");

    // R3 latch write, pins still inputs
    wrReg(2'd0, 8'h3C);
    check("R3 pinOut", pinOut, 8'h3C);
    check("R3 pinOe unchanged", pinOe, 8'h00);
    rdReg(2'd0, 8'hA5, "R4 read is pins not latch");
    rdReg(2'd1, 8'hFF, "R3 dir unchanged");

    // R2/R8 direction
    wrReg(2'd1, 8'hF0);
    check("R2 pinOe", pinOe, 8'h0F);
    check("R2 pinOut", pinOut, 8'h3C);
    rdReg(2'd1, 8'hF0, "R8 dir readback");
    settle();
    rdReg(2'd0, 8'hAC, "R4 mixed pins");

    // R7 pull-ups
    check("R7 disabled", pullUp, 8'h00);
    wrReg(2'd3, 8'h00);
    check("R7 enabled inputs only", pullUp, 8'hF0);
    wrReg(2'd1, 8'h0F);
    check("R7 follows direction", pullUp, 8'h0F);
    wrReg(2'd3, 8'h80);
    check("R7 disabled again", pullUp, 8'h00);
    wrReg(2'd1, 8'hF0);
    settle();

    // R6 read-modify-write copies input levels into the latch
    bitOp(3'd6, 1'b1, 1'b0);
    check("R6 rmw set", pinOut, 8'hEC);
    wrReg(2'd2, 8'h80);
    settle();
    bitOp(3'd0, 1'b1, 1'b0);
    check("R6 rmw masked", pinOut, 8'h2D);
    settle();
    bitOp(3'd1, 1'b1, 1'b1);
    check("R6 byte write ignored", pinOut, 8'h2F);
    settle();

    // R9 read and write in the same cycle
    @(negedge clk);
    expQ.push_back(8'h2F); tagQ.push_back("R9 read with write");
    addr = 2'd0; wrData = 8'h00; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R9 latch written", pinOut, 8'h00);

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    finished = 1;
    summary();
  end
endmodule